// File: doc/BRIEF.md
# Reset Cause and Request Register

This block is one 32-bit register that software uses for two jobs. It reads back why the system last came out of reset, and it asks for a new system reset. Five bits at the top of the word are live and the rest read as zero. Three of the live bits are status flags that software acknowledges by writing a one: power-on, button power-on and button externally-initiated reset. The other two are request bits that software sets by writing a one: software power-on and software externally-initiated reset. Setting either request bit sends a one-cycle pulse on the system-reset request output. The chip's reset logic then answers by asserting the block's system reset input.

The block keeps an internal flag that marks the next system reset as a power-on reset. Cold power-up sets the flag, and so does a software power-on request. The next system reset uses the flag and clears it. A reset counted as power-on loads the register with only the power-on status bit set. Any other system reset leaves the register as it was. Already-debounced button event inputs set the two button status bits.

Top module: `rst_cause_ctl`

## Requirements
- R1: While the cold power-up input `cold_n` is low, the register reads 0 and the request output is low. The first system reset after `cold_n` rises loads the register with 0x80000000.
- R2: Write data is masked to bits 31..27. Bits 26..0 always read 0.
- R3: Writing a one to bit 31, 28 or 27 clears that bit. Writing a zero there leaves it unchanged.
- R4: Writing a one to bit 30 or 29 sets that bit. Writing a zero there leaves it unchanged.
- R5: A write to the active word with bit 30 or bit 29 set drives `sys_rst_req` high for exactly the one cycle after the write. Other writes leave it low.
- R6: A write with bit 30 set arms a power-on reset. The next system reset (`rst_n` low at a clock edge) loads exactly 0x80000000, and later resets are not power-on unless the block is armed again.
- R7: A system reset that is not armed leaves the register unchanged. A write with only bit 29 set does not arm a power-on reset.
- R8: The only active address is the one whose bits 15..3 equal those of 0xF020 and whose bit 2 is 1, so 0xF024 with the default base. The word at 0xF020 and every other address read 0 and ignore writes.
- R9: A one-cycle high on `btn_por_evt` sets bit 28, and one on `btn_xir_evt` sets bit 27. If an event and a clearing write to the same bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_n | input | 1 | Cold power-up reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, sampled on the clock |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| btn_por_evt | input | 1 | Debounced button power-on event |
| btn_xir_evt | input | 1 | Debounced button externally-initiated reset event |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The properties assume that `rst_n` is only driven low after `cold_n` has risen, and that button events and bus writes are single clean cycles between clock edges. They also assume that a system reset clears a pending request rather than racing it. The stimulus drives every input on the falling clock edge and holds each write or event for exactly one cycle. It asserts the system reset only while the bus is idle. The one exact collision it creates is an event together with a clearing write, because that is the case R9 defines.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

   localparam int unsigned REG_W   = 32;
   localparam int unsigned B_POR   = 31;
   localparam int unsigned B_SPOR  = 30;
   localparam int unsigned B_SXIR  = 29;
   localparam int unsigned B_BPOR  = 28;
   localparam int unsigned B_BXIR  = 27;

   localparam logic [REG_W-1:0] LIVE_MASK = 32'hF800_0000;
   localparam logic [REG_W-1:0] POR_VAL   = 32'h8000_0000;

   typedef enum logic [1:0] {
      K_ZERO = 2'd0,
      K_W1C  = 2'd1,
      K_W1S  = 2'd2
   } bit_kind_e;

   function automatic bit_kind_e bit_kind(input int unsigned idx);
      case (idx)
         B_POR, B_BPOR, B_BXIR: return K_W1C;
         B_SPOR, B_SXIR:        return K_W1S;
         default:               return K_ZERO;
      endcase
   endfunction

endpackage

// File: rtl/rst_cause_decode.sv
module rst_cause_decode #(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] BASE = 16'hF020
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output logic              hit,
   output logic              wr_hit
);
   localparam int unsigned WORD_LSB = 3;

   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("rst_cause_decode: ADDR_W must be at least 4");
   end

   always_comb begin
      hit    = (addr[ADDR_W-1:WORD_LSB] == BASE[ADDR_W-1:WORD_LSB]) && addr[2];
      wr_hit = hit && wr;
   end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
   import rst_cause_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              cold_n,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   input  logic              btn_por_evt,
   input  logic              btn_xir_evt,
   output logic [DATA_W-1:0] q
);
   if (DATA_W != REG_W) begin : g_bad_data_w
      $error("rst_cause_reg: DATA_W must be 32");
   end

   logic [DATA_W-1:0] wm;
   logic [DATA_W-1:0] evt;
   logic [DATA_W-1:0] nxt;
   logic              arm_q;

   always_comb begin
      wm           = wr_hit ? (wdata & LIVE_MASK) : '0;
      evt          = '0;
      evt[B_BPOR]  = btn_por_evt;
      evt[B_BXIR]  = btn_xir_evt;
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (bit_kind(i) == K_W1C) begin : g_w1c
         assign nxt[i] = (q[i] & ~wm[i]) | evt[i];
      end else if (bit_kind(i) == K_W1S) begin : g_w1s
         assign nxt[i] = q[i] | wm[i];
      end else begin : g_zero
         assign nxt[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge cold_n) begin
      if (!cold_n) begin
         q     <= '0;
         arm_q <= 1'b1;
      end else if (!rst_n) begin
         if (arm_q) q <= POR_VAL;
         arm_q <= 1'b0;
      end else begin
         q <= nxt;
         if (wm[B_SPOR]) arm_q <= 1'b1;
      end
   end

   a_r6_por_load: assert property (@(posedge clk) disable iff (!cold_n)
      (!rst_n && arm_q) |=> (q == POR_VAL));
   a_r7_plain_reset_holds: assert property (@(posedge clk) disable iff (!cold_n)
      (!rst_n && !arm_q) |=> $stable(q));
   a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!cold_n || !rst_n)
      (wr_hit && wdata[B_POR]) |=> !q[B_POR]);
   a_r9_evt_wins: assert property (@(posedge clk) disable iff (!cold_n || !rst_n)
      btn_por_evt |=> q[B_BPOR]);
   a_r2_low_zero: assert property (@(posedge clk) disable iff (!cold_n)
      q[B_BXIR-1:0] == '0);
endmodule

// File: rtl/rst_cause_pulse.sv
module rst_cause_pulse (
   input  logic clk,
   input  logic cold_n,
   input  logic rst_n,
   input  logic trig,
   output logic pulse
);
   always_ff @(posedge clk or negedge cold_n) begin
      if (!cold_n)     pulse <= 1'b0;
      else if (!rst_n) pulse <= 1'b0;
      else             pulse <= trig;
   end

   a_r5_pulse_follows: assert property (@(posedge clk) disable iff (!cold_n || !rst_n)
      trig |=> pulse);
   a_r5_no_stray: assert property (@(posedge clk) disable iff (!cold_n || !rst_n)
      !trig |=> !pulse);
endmodule

// File: rtl/rst_cause_ctl.sv
module rst_cause_ctl
   import rst_cause_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 32,
   parameter logic [ADDR_W-1:0] BASE = 16'hF020
) (
   input  logic              clk,
   input  logic              cold_n,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              btn_por_evt,
   input  logic              btn_xir_evt,
   output logic              sys_rst_req
);
   logic              hit;
   logic              wr_hit;
   logic [DATA_W-1:0] q;
   logic              trig;

   rst_cause_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
      .addr   (bus_addr),
      .wr     (bus_wr),
      .hit    (hit),
      .wr_hit (wr_hit)
   );

   rst_cause_reg #(.DATA_W(DATA_W)) u_reg (
      .clk         (clk),
      .cold_n      (cold_n),
      .rst_n       (rst_n),
      .wr_hit      (wr_hit),
      .wdata       (bus_wdata),
      .btn_por_evt (btn_por_evt),
      .btn_xir_evt (btn_xir_evt),
      .q           (q)
   );

   assign trig = wr_hit && (bus_wdata[B_SPOR] || bus_wdata[B_SXIR]);

   rst_cause_pulse u_pulse (
      .clk    (clk),
      .cold_n (cold_n),
      .rst_n  (rst_n),
      .trig   (trig),
      .pulse  (sys_rst_req)
   );

   assign bus_rdata = hit ? q : '0;

   a_r8_miss_reads_zero: assert property (@(posedge clk) disable iff (!cold_n)
      !hit |-> (bus_rdata == '0));
   a_r1_quiet_in_cold: assert property (@(posedge clk)
      !cold_n |-> (!sys_rst_req && q == '0));
endmodule

// File: tb/rst_cause_ctl_tb.sv
module rst_cause_ctl_tb;
   logic        clk = 1'b0;
   logic        cold_n = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = 16'h0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        btn_por_evt = 1'b0;
   logic        btn_xir_evt = 1'b0;
   logic        sys_rst_req;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   localparam logic [15:0] ACT = 16'hF024;

   always #10 clk = ~clk;

   rst_cause_ctl u_dut (
      .clk(clk), .cold_n(cold_n), .rst_n(rst_n), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .btn_por_evt(btn_por_evt), .btn_xir_evt(btn_xir_evt),
      .sys_rst_req(sys_rst_req)
   );

   // {addr, wdata, expected register, expected request}
   localparam int NV = 9;
   localparam logic [80:0] VEC [NV] = '{
      {16'hF024, 32'h0000_0000, 32'h8000_0000, 1'b0}, // R3 R4 zero write
      {16'hF024, 32'h8000_0000, 32'h0000_0000, 1'b0}, // R3 clear bit 31
      {16'hF024, 32'h07FF_FFFF, 32'h0000_0000, 1'b0}, // R2 low bits dropped
      {16'hF020, 32'h6000_0000, 32'h0000_0000, 1'b0}, // R8 inactive word
      {16'hF024, 32'h2000_0000, 32'h2000_0000, 1'b1}, // R4 R5 set bit 29
      {16'hF024, 32'h2000_0000, 32'h2000_0000, 1'b1}, // R4 set again
      {16'hF024, 32'h1800_0000, 32'h2000_0000, 1'b0}, // R3 clear of zeros
      {16'hF02C, 32'hFFFF_FFFF, 32'h2000_0000, 1'b0}, // R8 other address
      {16'hF024, 32'h4000_0000, 32'h6000_0000, 1'b1}  // R4 R6 set bit 30
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input string req, input logic [31:0] exp);
      bus_addr = ACT;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic sys_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      bus_addr = ACT; #1;
      chk("R1 cold read", bus_rdata, 32'h0);
      chk("R1 cold req", {31'b0, sys_rst_req}, 32'h0);
      cold_n = 1'b1;
      @(negedge clk); rst_n = 1'b1;
      rd("R1 first reset", 32'h8000_0000);

      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][80:65], VEC[i][64:33]);
         chk($sformatf("R5 vec%0d req", i), {31'b0, sys_rst_req}, {31'b0, VEC[i][0]});
         rd($sformatf("R3/R4/R8 vec%0d", i), VEC[i][32:1]);
      end

      @(negedge clk);
      chk("R5 one cycle", {31'b0, sys_rst_req}, 32'h0);

      sys_reset();
      rd("R6 armed reset", 32'h8000_0000);
      sys_reset();
      rd("R7 unarmed reset", 32'h8000_0000);

      wr(ACT, 32'h2000_0000);
      chk("R5 xir req", {31'b0, sys_rst_req}, 32'h1);
      rd("R4 xir set", 32'hA000_0000);
      @(negedge clk);
      sys_reset();
      rd("R7 xir no arm", 32'hA000_0000);

      @(negedge clk); btn_por_evt = 1'b1;
      @(negedge clk); btn_por_evt = 1'b0;
      rd("R9 btn por", 32'hB000_0000);
      wr(ACT, 32'h1000_0000);
      rd("R3 clear bit 28", 32'hA000_0000);

      @(negedge clk);
      bus_addr = ACT; bus_wdata = 32'h0800_0000; bus_wr = 1'b1; btn_xir_evt = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; btn_xir_evt = 1'b0;
      rd("R9 event wins", 32'hA800_0000);
      wr(ACT, 32'h8800_0000);
      rd("R3 clear 31 and 27", 32'h2000_0000);

      bus_addr = 16'hF020; #1;
      chk("R8 inactive read", bus_rdata, 32'h0);

      @(negedge clk); cold_n = 1'b0; rst_n = 1'b0;
      bus_addr = ACT; #1;
      chk("R1 cold again", bus_rdata, 32'h0);
      @(negedge clk); cold_n = 1'b1;
      @(negedge clk); rst_n = 1'b1;
      rd("R1 reload after cold", 32'h8000_0000);

      finish_run();
   end
endmodule